// File: doc/BRIEF.md
# Pulse-Per-Second Edge Timestamp Unit

This block marks the rising edges of an external pulse-per-second signal against a free-running time base. It holds two counters that share one prescaled tick. The reference counter never stops. The elapsed counter is cleared by every qualified rising edge and then counts up. Host software does not need to catch the edge in time. It reads the two counters later and subtracts them. The result is the reference count at the instant of the edge, with the synchroniser delay as a fixed offset.

A single snapshot strobe captures the following values together in one clock cycle:
- the applied input level
- a sticky edge flag
- both counters

A two-bit select then reads the captured values, or their difference, from a register mux. An echo output follows the synchronised input for a status indicator. It can be inverted or forced low.

Top module: `pps_stamp`

## Requirements
- R1: The event input passes through SYNC_STAGES flops plus one applied-level flop. A change on event_i shows on the applied level, and so on echo_o, after SYNC_STAGES+1 rising clock edges.
- R2: The reference counter is CNT_W bits wide. It advances by one every PRESCALE clocks, starting at zero after reset, and wraps from all-ones to zero.
- R3: After reset the elapsed counter holds zero until the first rising edge of the applied level.
- R4: Each rising edge of the applied level sets the elapsed counter to zero. From then on it advances on the same ticks as the reference counter and wraps modulo 2^CNT_W.
- R5: A falling edge of the applied level changes neither the elapsed counter nor the edge flag.
- R6: Select value 3 reads (captured reference − captured elapsed) modulo 2^CNT_W.
- R7: A cycle with snap_i high captures the applied level, the edge flag and both counters as they stand before that clock edge. The captured values hold until the next strobe.
- R8: The edge flag is set by a rising edge and cleared by a strobe. If a rising edge and a strobe fall in the same cycle, the flag is set. Select value 0 reads the captured level in bit 0 and the captured flag in bit 1, with all other bits zero.
- R9: echo_o equals the applied level XOR echo_inv_i when echo_en_i is high, and is 0 when echo_en_i is low.
- R10: While rst_ni is low, all four select values read zero.
- R11: Select value 1 reads the captured reference count and select value 2 reads the captured elapsed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 1 | Asynchronous pulse-per-second input |
| snap_i | input | 1 | Snapshot strobe, also clears the edge flag |
| rd_sel_i | input | 2 | Read select: 0 status, 1 reference, 2 elapsed, 3 stamp |
| rd_data_o | output | CNT_W | Selected captured value |
| echo_en_i | input | 1 | Echo enable |
| echo_inv_i | input | 1 | Echo polarity invert |
| echo_o | output | 1 | Echo of the applied level |

## Verification
The bench aims at four corner cases.
- A strobe in the same cycle as a rising edge. A design that let the clear win would lose the event. A design that captured the counter after its reset would report a stale or zero stamp with a clear flag.
- The counter wraps. A design that got these wrong would produce a stamp that is off by 2^CNT_W, or a reference counter that sticks.
- Falling edges and a long idle time after reset. A design that reacted to either would restart the elapsed count spuriously.
- One-cycle pulses and the exact synchroniser latency, checked through the echo output. A design that was off by one stage would shift every timestamp.

// File: rtl/pps_stamp_pkg.sv
package pps_stamp_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_REF     = 2'd1,
    SEL_ELAPSED = 2'd2,
    SEL_STAMP   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              level_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[k] <= 1'b0;
      else if (k == 0) chain_q[k] <= event_i;
      else chain_q[k] <= chain_q[(k == 0) ? 0 : k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= chain_q[STAGES-1];
  end

  assign level_o = level_q;
  // rise is qualified against the applied level so counters and level agree
  assign rise_o  = chain_q[STAGES-1] & ~level_q;
endmodule

// File: rtl/pps_counters.sv
module pps_counters #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRESCALE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] ref_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             running_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             tick;
  logic [CNT_W-1:0] ref_q, el_q;
  logic             run_q;

  if (PRESCALE == 1) begin : g_nodiv
    assign tick = 1'b1;
  end else begin : g_div
    logic [PW-1:0] pc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       pc_q <= '0;
      else if (pc_q == PW'(PRESCALE-1))  pc_q <= '0;
      else                               pc_q <= pc_q + 1'b1;
    end
    assign tick = (pc_q == PW'(PRESCALE-1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      el_q  <= '0;
      run_q <= 1'b0;
    end else begin
      if (tick) ref_q <= ref_q + 1'b1;
      if (rise_i)             el_q <= '0;
      else if (run_q && tick) el_q <= el_q + 1'b1;
      if (rise_i) run_q <= 1'b1;
    end
  end

  assign ref_o     = ref_q;
  assign elapsed_o = el_q;
  assign running_o = run_q;
endmodule

// File: rtl/pps_capture.sv
module pps_capture
  import pps_stamp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_i,
  input  logic             rise_i,
  input  logic             level_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] elapsed_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] snap_ref_o
);
  logic             valid_q, s_level_q, s_valid_q;
  logic [CNT_W-1:0] s_ref_q, s_el_q;
  rd_sel_e          sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      s_level_q <= 1'b0;
      s_valid_q <= 1'b0;
      s_ref_q   <= '0;
      s_el_q    <= '0;
    end else begin
      if (rise_i)      valid_q <= 1'b1;  // set beats clear
      else if (snap_i) valid_q <= 1'b0;
      if (snap_i) begin
        s_level_q <= level_i;
        s_valid_q <= valid_q;
        s_ref_q   <= ref_i;
        s_el_q    <= elapsed_i;
      end
    end
  end

  assign sel = rd_sel_e'(rd_sel_i);

  always_comb begin
    unique case (sel)
      SEL_STATUS:  rd_data_o = {{(CNT_W-2){1'b0}}, s_valid_q, s_level_q};
      SEL_REF:     rd_data_o = s_ref_q;
      SEL_ELAPSED: rd_data_o = s_el_q;
      SEL_STAMP:   rd_data_o = s_ref_q - s_el_q;
      default:     rd_data_o = '0;
    endcase
  end

  assign valid_o    = valid_q;
  assign snap_ref_o = s_ref_q;
endmodule

// File: rtl/pps_stamp.sv
module pps_stamp #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRESCALE    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             snap_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             echo_en_i,
  input  logic             echo_inv_i,
  output logic             echo_o
);
  logic             level, rise, running, valid;
  logic [CNT_W-1:0] ref_cnt, el_cnt, snap_ref;

  pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .event_i,
    .level_o(level), .rise_o(rise)
  );

  pps_counters #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk_i, .rst_ni, .rise_i(rise),
    .ref_o(ref_cnt), .elapsed_o(el_cnt), .running_o(running)
  );

  pps_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni, .snap_i, .rise_i(rise), .level_i(level),
    .ref_i(ref_cnt), .elapsed_i(el_cnt), .rd_sel_i,
    .rd_data_o, .valid_o(valid), .snap_ref_o(snap_ref)
  );

  assign echo_o = echo_en_i & (level ^ echo_inv_i);
endmodule

// File: rtl/pps_stamp_chk.sv
module pps_stamp_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             snap_i,
  input logic             rise,
  input logic             running,
  input logic             valid,
  input logic [CNT_W-1:0] ref_cnt,
  input logic [CNT_W-1:0] el_cnt,
  input logic [CNT_W-1:0] snap_ref
);
  a_r2_ref_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ref_cnt == $past(ref_cnt)) || (ref_cnt == CNT_W'($past(ref_cnt) + 1'b1)));

  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> el_cnt == '0);

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> el_cnt == '0);

  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> valid);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && !snap_i) |=> valid);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_ref));
endmodule

bind pps_stamp pps_stamp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .snap_i(snap_i), .rise(rise),
  .running(running), .valid(valid), .ref_cnt(ref_cnt), .el_cnt(el_cnt),
  .snap_ref(snap_ref)
);

// File: tb/tb_pps_stamp.sv
`timescale 1ns/1ps
module tb_pps_stamp;
  localparam int W = 10, PRESC = 4, STG = 2;
  localparam int MOD = 1 << W;

  logic clk = 0, rst_ni = 0, event_i = 0, snap_i = 0, echo_en_i = 0, echo_inv_i = 0;
  logic [1:0]   rd_sel_i = 0;
  logic [W-1:0] rd_data_o;
  logic         echo_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pps_stamp #(.CNT_W(W), .PRESCALE(PRESC), .SYNC_STAGES(STG)) dut (
    .clk_i(clk), .rst_ni, .event_i, .snap_i, .rd_sel_i, .rd_data_o,
    .echo_en_i, .echo_inv_i, .echo_o);

  // behavioural reference
  bit hist[$];
  int m_lvl, m_ref, m_el, m_run, m_val, m_pc, s_lvl, s_ref, s_el, s_val;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {}; for (int i = 0; i < STG; i++) hist.push_back(0);
      m_lvl = 0; m_ref = 0; m_el = 0; m_run = 0; m_val = 0; m_pc = 0;
      s_lvl = 0; s_ref = 0; s_el = 0; s_val = 0;
    end else begin
      int syn, rise, tick, nel;
      syn  = hist[STG-1];
      rise = (syn == 1 && m_lvl == 0);
      tick = (m_pc == PRESC-1);
      if (snap_i) begin s_lvl = m_lvl; s_ref = m_ref; s_el = m_el; s_val = m_val; end
      if (rise) m_val = 1; else if (snap_i) m_val = 0;
      nel = rise ? 0 : ((m_run && tick) ? (m_el + 1) % MOD : m_el);
      m_el = nel;
      if (rise) m_run = 1;
      if (tick) m_ref = (m_ref + 1) % MOD;
      m_pc = tick ? 0 : m_pc + 1;
      m_lvl = syn;
      hist.push_front(event_i); void'(hist.pop_back());
    end
  end

  function automatic int exp_rd(int sel);
    case (sel)
      0: return s_val * 2 + s_lvl;
      1: return s_ref;
      2: return s_el;
      default: return (s_ref - s_el + MOD) % MOD;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_ni && !done) begin
    string tag;
    case (rd_sel_i)
      0: tag = "R8"; 1: tag = "R2"; 2: tag = "R4"; default: tag = "R6";
    endcase
    chk(tag, int'(rd_data_o), exp_rd(int'(rd_sel_i)));
    chk("R9", int'(echo_o), echo_en_i ? (m_lvl ^ int'(echo_inv_i)) : 0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic snap();
    @(negedge clk); #1 snap_i = 1;
    @(negedge clk); #1 snap_i = 0;
  endtask
  task automatic rd(int sel, output int v);
    @(negedge clk); #1 rd_sel_i = sel[1:0];
    @(negedge clk); v = int'(rd_data_o);
  endtask

  initial begin
    int a, b, c, r1, r2;
    bit seen_wrap;
    #1;
    for (int s = 0; s < 4; s++) begin
      rd_sel_i = s[1:0]; #2;
      chk("R10", int'(rd_data_o), 0);
    end
    cyc(3); rst_ni = 1;

    // R3: long idle, elapsed stays zero, flag clear
    cyc(60); snap();
    rd(2, a); chk("R3", a, 0);
    rd(0, a); chk("R3", a, 0);

    // R1: latency via echo
    echo_en_i = 1; cyc(1);
    @(negedge clk); #1 event_i = 1;
    @(negedge clk); chk("R1", int'(echo_o), 0);
    @(negedge clk); chk("R1", int'(echo_o), 0);
    @(negedge clk); chk("R1", int'(echo_o), 1);
    #1;

    // R8: flag set then cleared by strobe
    cyc(10); snap(); rd(0, a); chk("R8", a, 3);
    snap(); rd(0, a); chk("R8", a, 1);

    // R11/R6: stamp equals ref - elapsed
    cyc(37); snap();
    rd(1, a); rd(2, b); rd(3, c);
    chk("R11", a, s_ref); chk("R6", c, (a - b + MOD) % MOD);

    // R7: capture holds without strobe
    cyc(25); rd(1, r1); chk("R7", r1, a);

    // R5: falling edge leaves elapsed running and flag clear
    @(negedge clk); #1 event_i = 0;
    cyc(20); snap(); rd(0, a); chk("R5", a, 0);
    rd(2, b); chk("R5", b, s_el);

    // R9: echo polarity and enable
    echo_inv_i = 1; cyc(1); chk("R9", int'(echo_o), 1);
    echo_en_i = 0;  cyc(1); chk("R9", int'(echo_o), 0);
    echo_en_i = 1; echo_inv_i = 0;

    // rising edge coincident with strobe: set wins
    @(negedge clk); #1 event_i = 1;
    cyc(2); snap_i = 1; cyc(1); snap_i = 0;
    rd(0, a); chk("R8", a & 2, 0);
    snap(); rd(0, a); chk("R8", a, 3);
    rd(2, b); chk("R4", b, s_el);

    // one-cycle pulses
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1 event_i = 0; cyc(3 + k);
      event_i = 1; cyc(1); event_i = 0; cyc(9 + 2 * k);
      snap(); rd(3, a); chk("R6", a, exp_rd(3));
    end

    // R2: long run across a counter wrap
    seen_wrap = 0; r2 = 0;
    for (int k = 0; k < 60; k++) begin
      cyc(97); snap(); rd(1, r1);
      if (r1 < r2) seen_wrap = 1;
      r2 = r1;
      if (k == 30) begin event_i = 1; cyc(5); event_i = 0; end
    end
    chk("R2", int'(seen_wrap), 1);
    rd(3, a); chk("R6", a, exp_rd(3));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule